// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block resolves the flow of control for one instruction of a small 16-bit processor. Given the address of the instruction, the instruction word, the four stored condition flags and one register operand, it works out where execution continues, whether a transfer of control happened, and the value (if any) that goes back into a register. Memory sequencing and flag generation live elsewhere; this unit only consumes the flags.

A request is presented for one cycle with `req_valid`. One clock edge later the result is on the outputs, with `res_valid` high for that cycle. A small two-state controller sequences this. `ST_IDLE` means no result is on the outputs. `ST_ISSUE` means a registered result is on the outputs. The transition `IDLE->ISSUE` is taken on a request. `ISSUE->ISSUE` is taken on a back-to-back request. `ISSUE->IDLE` is taken when no request follows. In `ST_IDLE` the strobes `taken`, `link_we` and `illegal` are held low.

The unit handles several instruction kinds. Control-transfer instructions have bit 15 set. They carry a 3-bit condition code in bits 14:12, a polarity bit in bit 11 and a signed 11-bit offset in bits 10:0. Each condition code selects a flag expression. The branch is taken when that expression equals the polarity bit, so every code gives a complementary pair of branches. Three further instructions use an 8-bit signed offset in bits 7:0: jump-and-link, register-indirect jump and address generation.

Top module: `nxp_unit`

## Requirements
- R1: After reset, `res_valid`, `taken`, `link_we` and `illegal` are 0 and `next_pc` is 0; while no result is presented (`res_valid`=0) the three strobes stay 0.
- R2: A request sampled at a rising edge produces its result, with `res_valid`=1, from that edge until the next one; `res_valid` is 0 in any cycle following an edge at which `req_valid` was 0.
- R3: For an instruction with bit 15 = 1, the flag expression is chosen by bits 14:12 as follows: 001 Z, 010 S, 011 O, 100 C, 101 (C or Z), 110 (S xor O), 111 ((S xor O) or Z). The flag bits are `flags_in[0]`=Z, `flags_in[1]`=S, `flags_in[2]`=C and `flags_in[3]`=O. `taken` is 1 exactly when the expression equals bit 11.
- R4: For a bit-15 instruction, when taken, `next_pc` = pc+1+sign-extended bits 10:0. When not taken, `next_pc` = pc+1. `link_we` is 0.
- R5: Code 000 with bit 11 = 0 is always taken, whatever the flags.
- R6: Code 000 with bit 11 = 1 is not taken. It gives `next_pc` = pc+1 and `link_we`=0, and raises `illegal` for exactly the one result cycle.
- R7: Jump-and-link (bits 15:11 = 01110) gives `link_val` = pc+1, `link_we`=1, `taken`=1 and `next_pc` = pc+1+sign-extended bits 7:0.
- R8: Register-indirect jump (bits 15:11 = 01111) gives `next_pc` = `reg_in`+sign-extended bits 7:0, `taken`=1 and `link_we`=0.
- R9: Address generation (bits 15:11 = 01001) gives `link_val` = pc+1+sign-extended bits 7:0 and `link_we`=1. It does not redirect control: `taken`=0 and `next_pc` = pc+1.
- R10: Every other instruction gives `next_pc` = pc+1 with `taken`, `link_we` and `illegal` all 0.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; samples the inputs below |
| pc_in | input | 16 | Address of the instruction |
| instr_in | input | 16 | Instruction word |
| flags_in | input | 4 | Stored flags {O,C,S,Z} |
| reg_in | input | 16 | Register operand for indirect jump |
| res_valid | output | 1 | Result present this cycle |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Control transfer occurred |
| link_we | output | 1 | `link_val` is to be written to a register |
| link_val | output | 16 | Return address or generated address |
| illegal | output | 1 | Unassigned control-transfer code seen |

## Verification
The assertions check the following properties on every cycle:
- the one-edge request-to-result timing and the quiet strobes while idle;
- that `illegal` never coincides with a transfer or a register write;
- that any result that does not redirect control lands on pc+1;
- that jump-and-link returns pc+1;
- that an unconditional jump and address generation have the right strobe pattern.

The correctness of each of the fourteen condition polarities against particular flag patterns can only be shown by the bench's scenarios. The same holds for the signed offsets at their extremes, for wrap-around at the top of the address space, and for indirect targets.

// File: rtl/nxp_pkg.sv
package nxp_pkg;

    typedef enum logic [2:0] {
        OK_PLAIN,
        OK_BRANCH,
        OK_BAD,
        OK_CALL,
        OK_INDIRECT,
        OK_ADDRGEN
    } op_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } nxp_state_e;

    localparam logic [4:0] PFX_CALL     = 5'b01110;
    localparam logic [4:0] PFX_INDIRECT = 5'b01111;
    localparam logic [4:0] PFX_ADDRGEN  = 5'b01001;

    localparam int FLAG_Z = 0;
    localparam int FLAG_S = 1;
    localparam int FLAG_C = 2;
    localparam int FLAG_O = 3;

endpackage

// File: rtl/nxp_decode.sv
module nxp_decode
    import nxp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output op_kind_e           kind,
    output logic [2:0]         cond,
    output logic               pol,
    output logic [ADDR_W-1:0]  off_long,
    output logic [ADDR_W-1:0]  off_short
);
    localparam int LONG_W  = 11;
    localparam int SHORT_W = 8;

    logic [4:0] prefix;

    assign prefix    = instr[15:11];
    assign cond      = instr[14:12];
    assign pol       = instr[11];
    assign off_long  = {{(ADDR_W-LONG_W){instr[LONG_W-1]}},  instr[LONG_W-1:0]};
    assign off_short = {{(ADDR_W-SHORT_W){instr[SHORT_W-1]}}, instr[SHORT_W-1:0]};

    always_comb begin
        if (instr[15]) begin
            kind = (cond == 3'b000 && pol) ? OK_BAD : OK_BRANCH;
        end else begin
            unique case (prefix)
                PFX_CALL:     kind = OK_CALL;
                PFX_INDIRECT: kind = OK_INDIRECT;
                PFX_ADDRGEN:  kind = OK_ADDRGEN;
                default:      kind = OK_PLAIN;
            endcase
        end
    end
endmodule

// File: rtl/nxp_cond.sv
module nxp_cond
    import nxp_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [2:0]        cond,
    input  logic              pol,
    output logic              hit
);
    logic expr;
    logic lt;

    assign lt = flags[FLAG_S] ^ flags[FLAG_O];

    always_comb begin
        unique case (cond)
            3'b000: expr = 1'b0;
            3'b001: expr = flags[FLAG_Z];
            3'b010: expr = flags[FLAG_S];
            3'b011: expr = flags[FLAG_O];
            3'b100: expr = flags[FLAG_C];
            3'b101: expr = flags[FLAG_C] | flags[FLAG_Z];
            3'b110: expr = lt;
            3'b111: expr = lt | flags[FLAG_Z];
            default: expr = 1'b0;
        endcase
    end

    assign hit = (expr == pol);
endmodule

// File: rtl/nxp_target.sv
module nxp_target
    import nxp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  op_kind_e          kind,
    input  logic              hit,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] rval,
    input  logic [ADDR_W-1:0] off_long,
    input  logic [ADDR_W-1:0] off_short,
    output logic [ADDR_W-1:0] nxt,
    output logic              xfer,
    output logic              wr,
    output logic [ADDR_W-1:0] wval,
    output logic              bad
);
    logic [ADDR_W-1:0] seq;
    logic [ADDR_W-1:0] rel_long;
    logic [ADDR_W-1:0] rel_short;

    assign seq       = pc + ADDR_W'(1);
    assign rel_long  = seq + off_long;
    assign rel_short = seq + off_short;

    always_comb begin
        nxt  = seq;
        xfer = 1'b0;
        wr   = 1'b0;
        wval = seq;
        bad  = 1'b0;
        unique case (kind)
            OK_BRANCH: begin
                xfer = hit;
                nxt  = hit ? rel_long : seq;
            end
            OK_BAD: bad = 1'b1;
            OK_CALL: begin
                xfer = 1'b1;
                nxt  = rel_short;
                wr   = 1'b1;
                wval = seq;
            end
            OK_INDIRECT: begin
                xfer = 1'b1;
                nxt  = rval + off_short;
            end
            OK_ADDRGEN: begin
                wr   = 1'b1;
                wval = rel_short;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nxp_unit.sv
module nxp_unit
    import nxp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int FLAG_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic [FLAG_W-1:0]  flags_in,
    input  logic [ADDR_W-1:0]  reg_in,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  next_pc,
    output logic               taken,
    output logic               link_we,
    output logic [ADDR_W-1:0]  link_val,
    output logic               illegal
);
    nxp_state_e state_q, state_nx;

    op_kind_e          kind;
    logic [2:0]        cond;
    logic              pol;
    logic              hit;
    logic [ADDR_W-1:0] off_long, off_short;
    logic [ADDR_W-1:0] nxt_c, wval_c;
    logic              xfer_c, wr_c, bad_c;

    logic [ADDR_W-1:0] nxt_q, wval_q;
    logic              xfer_q, wr_q, bad_q;

    nxp_decode #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_dec (
        .instr     (instr_in),
        .kind      (kind),
        .cond      (cond),
        .pol       (pol),
        .off_long  (off_long),
        .off_short (off_short)
    );

    nxp_cond #(.FLAG_W(FLAG_W)) u_cond (
        .flags (flags_in),
        .cond  (cond),
        .pol   (pol),
        .hit   (hit)
    );

    nxp_target #(.ADDR_W(ADDR_W)) u_tgt (
        .kind      (kind),
        .hit       (hit),
        .pc        (pc_in),
        .rval      (reg_in),
        .off_long  (off_long),
        .off_short (off_short),
        .nxt       (nxt_c),
        .xfer      (xfer_c),
        .wr        (wr_c),
        .wval      (wval_c),
        .bad       (bad_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_nx = req_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_nx = req_valid ? ST_ISSUE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            wval_q <= '0;
            xfer_q <= 1'b0;
            wr_q   <= 1'b0;
            bad_q  <= 1'b0;
        end else if (req_valid) begin
            nxt_q  <= nxt_c;
            wval_q <= wval_c;
            xfer_q <= xfer_c;
            wr_q   <= wr_c;
            bad_q  <= bad_c;
        end
    end

    assign res_valid = (state_q == ST_ISSUE);
    assign next_pc   = nxt_q;
    assign link_val  = wval_q;
    assign taken     = res_valid & xfer_q;
    assign link_we   = res_valid & wr_q;
    assign illegal   = res_valid & bad_q;
endmodule

// File: rtl/nxp_unit_chk.sv
module nxp_unit_chk #(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  pc_in,
    input logic [INSTR_W-1:0] instr_in,
    input logic               res_valid,
    input logic [ADDR_W-1:0]  next_pc,
    input logic               taken,
    input logic               link_we,
    input logic [ADDR_W-1:0]  link_val,
    input logic               illegal
);
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!taken && !link_we && !illegal));

    a_r6_illegal_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && !link_we));

    a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (taken || next_pc == $past(pc_in) + ADDR_W'(1)));

    a_r7_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr_in[15:11] == 5'b01110) |=> (link_we && taken && link_val == $past(pc_in) + ADDR_W'(1)));

    a_r5_always_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr_in[15:11] == 5'b10000) |=> taken);

    a_r9_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr_in[15:11] == 5'b01001) |=> (!taken && link_we));
endmodule

bind nxp_unit nxp_unit_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pc_in     (pc_in),
    .instr_in  (instr_in),
    .res_valid (res_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_val  (link_val),
    .illegal   (illegal)
);

// File: tb/nxp_unit_test.sv
module nxp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] pc_in = '0, instr_in = '0, reg_in = '0;
    logic [3:0]  flags_in = '0;
    logic        res_valid, taken, link_we, illegal;
    logic [15:0] next_pc, link_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nxp_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc_in(pc_in),
        .instr_in(instr_in), .flags_in(flags_in), .reg_in(reg_in),
        .res_valid(res_valid), .next_pc(next_pc), .taken(taken),
        .link_we(link_we), .link_val(link_val), .illegal(illegal)
    );

    typedef struct packed {
        logic [15:0] npc;
        logic        tk;
        logic        we;
        logic [15:0] lv;
        logic        bad;
        logic        use_lv;
    } exp_t;

    function automatic logic flag_expr(input logic [2:0] c, input logic [3:0] f);
        logic z, s, cy, o;
        z = f[0]; s = f[1]; cy = f[2]; o = f[3];
        case (c)
            3'd1: return z;
            3'd2: return s;
            3'd3: return o;
            3'd4: return cy;
            3'd5: return cy | z;
            3'd6: return s ^ o;
            3'd7: return (s ^ o) | z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t model(input logic [15:0] pc, input logic [15:0] ins,
                                   input logic [3:0] f, input logic [15:0] r);
        exp_t e;
        logic [15:0] s8, s11;
        s8  = 16'($signed(ins[7:0]));
        s11 = 16'($signed(ins[10:0]));
        e = '0;
        e.npc = pc + 16'd1;
        if (ins[15]) begin
            if (ins[14:12] == 3'd0) begin
                if (ins[11]) e.bad = 1'b1;
                else begin e.tk = 1'b1; e.npc = pc + 16'd1 + s11; end
            end else if (flag_expr(ins[14:12], f) == ins[11]) begin
                e.tk = 1'b1; e.npc = pc + 16'd1 + s11;
            end
        end else if (ins[15:11] == 5'b01110) begin
            e.tk = 1'b1; e.we = 1'b1; e.use_lv = 1'b1;
            e.lv = pc + 16'd1; e.npc = pc + 16'd1 + s8;
        end else if (ins[15:11] == 5'b01111) begin
            e.tk = 1'b1; e.npc = r + s8;
        end else if (ins[15:11] == 5'b01001) begin
            e.we = 1'b1; e.use_lv = 1'b1; e.lv = pc + 16'd1 + s8;
        end
        return e;
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [15:0] pc, input logic [15:0] ins,
                          input logic [3:0] f, input logic [15:0] r, input bit chk_idle);
        exp_t e;
        e = model(pc, ins, f, r);
        @(negedge clk);
        pc_in = pc; instr_in = ins; flags_in = f; reg_in = r; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "res_valid", 16'(res_valid), 16'd1);
        check(tag, "next_pc", next_pc, e.npc);
        check(tag, "taken", 16'(taken), 16'(e.tk));
        check(tag, "link_we", 16'(link_we), 16'(e.we));
        check(tag, "illegal", 16'(illegal), 16'(e.bad));
        if (e.use_lv) check(tag, "link_val", link_val, e.lv);
        if (chk_idle) begin
            @(negedge clk);
            check("R2", "res_valid idle", 16'(res_valid), 16'd0);
            check("R6", "illegal strobe width", 16'(illegal), 16'd0);
            check("R1", "taken idle", 16'(taken), 16'd0);
        end
    endtask

    function automatic logic [15:0] br(input logic [2:0] c, input logic p, input logic [10:0] off);
        return {1'b1, c, p, off};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "res_valid", 16'(res_valid), 16'd0);
        check("R1", "next_pc", next_pc, 16'd0);
        check("R1", "strobes", {13'd0, taken, link_we, illegal}, 16'd0);
        rst_n = 1'b1;

        // R3 every code, both polarities, all flag patterns
        for (int c = 1; c < 8; c++)
            for (int p = 0; p < 2; p++)
                for (int f = 0; f < 16; f++)
                    run_op("R3", 16'h1000, br(3'(c), 1'(p), 11'h010), 4'(f), 16'h0, 1'b0);
        // R4 offset extremes, R11 wrap
        run_op("R4", 16'h0400, br(3'd0, 1'b0, 11'h400), 4'h0, 16'h0, 1'b1);
        run_op("R4", 16'h0400, br(3'd0, 1'b0, 11'h3FF), 4'h0, 16'h0, 1'b1);
        run_op("R4", 16'h2000, br(3'd1, 1'b1, 11'h7FF), 4'h0, 16'h0, 1'b1);
        run_op("R11", 16'hFFFF, br(3'd0, 1'b0, 11'h005), 4'h0, 16'h0, 1'b1);
        run_op("R11", 16'h0002, br(3'd0, 1'b0, 11'h400), 4'h0, 16'h0, 1'b1);
        // R5 unconditional regardless of flags
        for (int f = 0; f < 16; f++) run_op("R5", 16'h0100, br(3'd0, 1'b0, 11'h020), 4'(f), 16'h0, 1'b0);
        // R6 unassigned code
        run_op("R6", 16'h0300, br(3'd0, 1'b1, 11'h020), 4'hF, 16'h0, 1'b1);
        run_op("R6", 16'hFFFF, br(3'd0, 1'b1, 11'h7FF), 4'h0, 16'h0, 1'b1);
        // R7 call, R8 indirect, R9 address generation
        run_op("R7", 16'h1234, {5'b01110, 3'd2, 8'h80}, 4'h0, 16'h0, 1'b1);
        run_op("R7", 16'hFFFF, {5'b01110, 3'd5, 8'h7F}, 4'h0, 16'h0, 1'b1);
        run_op("R8", 16'h1234, {5'b01111, 3'd1, 8'hFE}, 4'h0, 16'h5000, 1'b1);
        run_op("R8", 16'h0000, {5'b01111, 3'd1, 8'h10}, 4'h0, 16'hFFF8, 1'b1);
        run_op("R9", 16'h4000, {5'b01001, 3'd3, 8'h80}, 4'h0, 16'h0, 1'b1);
        run_op("R9", 16'hFFFE, {5'b01001, 3'd3, 8'h05}, 4'h0, 16'h0, 1'b1);
        // R10 other instructions
        run_op("R10", 16'h0777, 16'h0123, 4'hF, 16'h0, 1'b1);
        run_op("R10", 16'hFFFF, {5'b01010, 11'h7FF}, 4'h0, 16'h0, 1'b1);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] ins;
            logic [15:0] rnd;
            string tag;
            rnd = 16'($urandom);
            case ($urandom % 5)
                0: begin ins = {1'b1, rnd[14:0]}; tag = "R3"; end
                1: begin ins = {5'b01110, rnd[10:0]}; tag = "R7"; end
                2: begin ins = {5'b01111, rnd[10:0]}; tag = "R8"; end
                3: begin ins = {5'b01001, rnd[10:0]}; tag = "R9"; end
                default: begin ins = {1'b0, rnd[14:0]}; tag = "R10"; end
            endcase
            run_op(tag, 16'($urandom), ins, 4'($urandom), 16'($urandom), ($urandom % 4) == 0);
        end

        done = 1'b1;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule